// File: doc/BRIEF.md
# Cache Line Coherence State Controller

This block keeps the four-state coherence record (state plus dirty flag) for a small array of cache lines and advances it for each local read or write request. Requests arrive one at a time with a line index, a write bit and a valid strobe. Some requests can complete locally. Others need a coherence action from an external agent first: a shared fill, an exclusive fill, or an invalidation of the copies held elsewhere. The agent answers each action with success or failure.

The controller handles one request at a time. While an action is outstanding it holds its request port not ready. The outcome appears as a single-cycle completion pulse that carries a success bit, the resulting state and the dirty flag. A fill caused by a read always lands in Shared. A failed action leaves the record untouched. Data, tags, remote snoops and the bus protocol belong to other blocks.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (code 00) with dirty clear. `req_ready` is 1, and `coh_req_valid` and `done` are 0.
- R2: A read of a line in Shared (01), Exclusive (10) or Modified (11) raises no coherence action. `done` pulses in the cycle after acceptance with `done_ok`=1, and state and dirty are unchanged.
- R3: A read of an Invalid line raises action code 01 (shared fill) with the line index. On success the line becomes Shared with dirty clear.
- R4: A write to an Invalid line raises action code 10 (exclusive fill). On success the line becomes Modified with dirty set.
- R5: A write to a Shared line raises action code 11 (invalidate other copies). On success the line becomes Modified with dirty set.
- R6: A write to a Modified or Exclusive line raises no action. It completes in the cycle after acceptance as Modified with dirty set.
- R7: When the agent reports failure, the line's state and dirty flag stay as they were, and `done` pulses with `done_ok`=0 and the unchanged state.
- R8: From acceptance of a request that needs an action until the agent responds, `req_ready` is 0 and `coh_req_valid` stays high with a stable op and index. Request strobes seen in that window are ignored.
- R9: Each accepted request produces exactly one `done` pulse, one cycle long. It appears one cycle after acceptance when no action is needed, or one cycle after the agent's response. It carries the resulting state and dirty flag of the addressed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request strobe |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_idx | input | IDX_W | Line addressed by the request |
| req_write | input | 1 | 1 = write, 0 = read |
| coh_req_valid | output | 1 | Coherence action outstanding |
| coh_req_op | output | 2 | Action code: 01 shared fill, 10 exclusive fill, 11 invalidate others |
| coh_req_idx | output | IDX_W | Line the action concerns |
| coh_rsp_valid | input | 1 | Agent response strobe |
| coh_rsp_ok | input | 1 | Agent response: 1 success, 0 failure |
| done | output | 1 | Completion pulse |
| done_ok | output | 1 | Request succeeded |
| done_state | output | 2 | Resulting line state code |
| done_dirty | output | 1 | Resulting dirty flag |

## Verification
The hardest situations to reach are the ones that need a line already in a particular state when a request arrives. Two examples are a write to a Shared line whose invalidation then fails, and a stray request strobe during a long agent stall. The bench reaches them with a pseudo-random stream of reads and writes over all lines. It mixes in agent failures and varying response delays, and it tracks every line's expected record arithmetically, so Shared lines exist before writes hit them. It also re-asserts the request strobe with another index while an action is pending.

The Exclusive state is never entered from these ports, because every fill lands in Shared or Modified. The Exclusive branch of R6 is therefore guarded by the transition logic and its assertions, not reached by stimulus.

// File: rtl/mesi_lc_pkg.sv
package mesi_lc_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        CA_NONE    = 2'b00,
        CA_GET_SHR = 2'b01,
        CA_GET_EXC = 2'b10,
        CA_KILL    = 2'b11
    } coh_act_e;

    typedef struct packed {
        line_st_e st;
        logic     dirty;
    } line_rec_t;

    typedef struct packed {
        coh_act_e  act;
        line_rec_t on_ok;
    } xition_t;

endpackage

// File: rtl/mesi_xition.sv
module mesi_xition
    import mesi_lc_pkg::*;
(
    input  line_rec_t cur,
    input  logic      is_wr,
    output xition_t   res
);

    always_comb begin
        res.act   = CA_NONE;
        res.on_ok = cur;
        if (!is_wr) begin
            if (cur.st == LS_INV) begin
                res.act         = CA_GET_SHR;
                res.on_ok.st    = LS_SHR;
                res.on_ok.dirty = 1'b0;
            end
        end else begin
            res.on_ok.st    = LS_MOD;
            res.on_ok.dirty = 1'b1;
            unique case (cur.st)
                LS_INV:  res.act = CA_GET_EXC;
                LS_SHR:  res.act = CA_KILL;
                default: res.act = CA_NONE;
            endcase
        end
    end

    // R6: a write that needs no action always starts from Exclusive or Modified
    always_comb begin
        if (is_wr && res.act == CA_NONE)
            assert_wr_local_R6: assert (cur.st == LS_EXC || cur.st == LS_MOD);
    end

endmodule

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_lc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output line_rec_t        rd_rec,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_rec_t        wr_rec
);

    line_rec_t                rec_d [NUM_LINES];
    line_rec_t                rec_q [NUM_LINES];
    logic [NUM_LINES-1:0]     we_vec;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign we_vec[g] = wr_en && (wr_idx == IDX_W'(g));

        always_comb begin
            rec_d[g] = rec_q[g];
            if (we_vec[g])
                rec_d[g] = wr_rec;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                rec_q[g] <= '{st: LS_INV, dirty: 1'b0};
            else
                rec_q[g] <= rec_d[g];
        end
    end

    assign rd_rec = rec_q[rd_idx];

    // R9: at most one line record changes per cycle
    assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

endmodule

// File: rtl/mesi_seq_ctl.sv
module mesi_seq_ctl
    import mesi_lc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_idx,
    input  line_rec_t        cur_rec,
    input  xition_t          xres,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output line_rec_t        wr_rec,
    output logic             coh_req_valid,
    output logic [1:0]       coh_req_op,
    output logic [IDX_W-1:0] coh_req_idx,
    input  logic             coh_rsp_valid,
    input  logic             coh_rsp_ok,
    output logic             done,
    output logic             done_ok,
    output logic [1:0]       done_state,
    output logic             done_dirty
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        coh_act_e         act;
        line_rec_t        cur;
        line_rec_t        tgt;
        logic             done;
        logic             ok;
        line_rec_t        res;
    } ctl_t;

    ctl_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        wr_en    = 1'b0;
        wr_idx   = r_q.idx;
        wr_rec   = r_q.tgt;
        if (!r_q.busy) begin
            if (req_valid) begin
                if (xres.act == CA_NONE) begin
                    wr_en     = 1'b1;
                    wr_idx    = req_idx;
                    wr_rec    = xres.on_ok;
                    r_d.done  = 1'b1;
                    r_d.ok    = 1'b1;
                    r_d.res   = xres.on_ok;
                end else begin
                    r_d.busy  = 1'b1;
                    r_d.idx   = req_idx;
                    r_d.act   = xres.act;
                    r_d.cur   = cur_rec;
                    r_d.tgt   = xres.on_ok;
                end
            end
        end else if (coh_rsp_valid) begin
            r_d.busy = 1'b0;
            r_d.act  = CA_NONE;
            r_d.done = 1'b1;
            r_d.ok   = coh_rsp_ok;
            if (coh_rsp_ok) begin
                wr_en   = 1'b1;
                r_d.res = r_q.tgt;
            end else begin
                r_d.res = r_q.cur;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign req_ready     = !r_q.busy;
    assign coh_req_valid = r_q.busy;
    assign coh_req_op    = r_q.act;
    assign coh_req_idx   = r_q.idx;
    assign done          = r_q.done;
    assign done_ok       = r_q.ok;
    assign done_state    = r_q.res.st;
    assign done_dirty    = r_q.res.dirty;

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        coh_req_valid |-> !req_ready);

    assert_hold_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (coh_req_valid && !coh_rsp_valid) |=>
            (coh_req_valid && $stable(coh_req_op) && $stable(coh_req_idx)));

    assert_action_coded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        coh_req_valid |-> (coh_req_op != 2'b00));

    assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(req_valid && req_ready) || $past(coh_req_valid && coh_rsp_valid)));

    assert_fail_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> ((done_state == 2'b00 || done_state == 2'b01) && !done_dirty));

    assert_mod_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_state == 2'b11) |-> done_dirty);

    assert_shr_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_state == 2'b01) |-> !done_dirty);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_lc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             req_write,
    output logic             coh_req_valid,
    output logic [1:0]       coh_req_op,
    output logic [IDX_W-1:0] coh_req_idx,
    input  logic             coh_rsp_valid,
    input  logic             coh_rsp_ok,
    output logic             done,
    output logic             done_ok,
    output logic [1:0]       done_state,
    output logic             done_dirty
);

    line_rec_t        cur_rec;
    xition_t          xres;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    line_rec_t        wr_rec;

    mesi_line_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_rec (cur_rec),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_rec (wr_rec)
    );

    mesi_xition u_xition (
        .cur   (cur_rec),
        .is_wr (req_write),
        .res   (xres)
    );

    mesi_seq_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_idx       (req_idx),
        .cur_rec       (cur_rec),
        .xres          (xres),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_rec        (wr_rec),
        .coh_req_valid (coh_req_valid),
        .coh_req_op    (coh_req_op),
        .coh_req_idx   (coh_req_idx),
        .coh_rsp_valid (coh_rsp_valid),
        .coh_rsp_ok    (coh_rsp_ok),
        .done          (done),
        .done_ok       (done_ok),
        .done_state    (done_state),
        .done_dirty    (done_dirty)
    );

endmodule

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;

    localparam int NL = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [IW-1:0] req_idx = '0;
    logic          req_write = 1'b0;
    logic          coh_req_valid;
    logic [1:0]    coh_req_op;
    logic [IW-1:0] coh_req_idx;
    logic          coh_rsp_valid = 1'b0;
    logic          coh_rsp_ok = 1'b0;
    logic          done, done_ok, done_dirty;
    logic [1:0]    done_state;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [1:0] m_st [NL];
    logic       m_dt [NL];

    always #4 clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_idx(req_idx), .req_write(req_write), .coh_req_valid(coh_req_valid),
        .coh_req_op(coh_req_op), .coh_req_idx(coh_req_idx),
        .coh_rsp_valid(coh_rsp_valid), .coh_rsp_ok(coh_rsp_ok), .done(done),
        .done_ok(done_ok), .done_state(done_state), .done_dirty(done_dirty)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one request; stall = response delay cycles; poke = strobe another request while pending
    task automatic run_req(input int idx, input bit wr, input bit ok,
                           input int stall, input bit poke);
        logic [1:0] cur_s = m_st[idx];
        logic [1:0] e_op;
        logic [1:0] ok_s;
        logic       ok_d;
        string      rq;
        if (!wr) begin
            e_op = (cur_s == 2'b00) ? 2'b01 : 2'b00;
            ok_s = (cur_s == 2'b00) ? 2'b01 : cur_s;
            ok_d = (cur_s == 2'b00) ? 1'b0 : m_dt[idx];
            rq   = (cur_s == 2'b00) ? "R3" : "R2";
        end else begin
            e_op = (cur_s == 2'b00) ? 2'b10 : (cur_s == 2'b01) ? 2'b11 : 2'b00;
            ok_s = 2'b11;
            ok_d = 1'b1;
            rq   = (cur_s == 2'b00) ? "R4" : (cur_s == 2'b01) ? "R5" : "R6";
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_idx = IW'(idx); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (e_op == 2'b00) begin
            chk(coh_req_valid == 1'b0, rq, "no action", int'(coh_req_valid), 0);
            chk(done == 1'b1 && done_ok == 1'b1, "R9", "local done/ok",
                int'({done, done_ok}), 3);
            chk(done_state == ok_s, rq, "state", int'(done_state), int'(ok_s));
            chk(done_dirty == ok_d, rq, "dirty", int'(done_dirty), int'(ok_d));
            m_st[idx] = ok_s; m_dt[idx] = ok_d;
        end else begin
            if (poke) begin
                req_valid = 1'b1; req_idx = IW'(idx ^ 1); req_write = 1'b1;
            end
            chk(coh_req_valid == 1'b1 && coh_req_op == e_op, rq, "action op",
                int'(coh_req_op), int'(e_op));
            chk(coh_req_idx == IW'(idx), rq, "action idx", int'(coh_req_idx), idx);
            chk(req_ready == 1'b0 && done == 1'b0, "R8", "busy ready/done",
                int'({req_ready, done}), 0);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(coh_req_valid == 1'b1 && coh_req_op == e_op && req_ready == 1'b0,
                    "R8", "hold during stall", int'(coh_req_op), int'(e_op));
            end
            req_valid = 1'b0;
            coh_rsp_valid = 1'b1; coh_rsp_ok = ok;
            @(negedge clk);
            coh_rsp_valid = 1'b0;
            chk(done == 1'b1 && done_ok == ok, ok ? rq : "R7", "done/ok",
                int'({done, done_ok}), int'({1'b1, ok}));
            if (ok) begin
                m_st[idx] = ok_s; m_dt[idx] = ok_d;
            end
            chk(done_state == m_st[idx], ok ? rq : "R7", "state",
                int'(done_state), int'(m_st[idx]));
            chk(done_dirty == m_dt[idx], ok ? rq : "R7", "dirty",
                int'(done_dirty), int'(m_dt[idx]));
            chk(coh_req_valid == 1'b0, "R8", "action dropped", int'(coh_req_valid), 0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9", "single pulse", int'(done), 0);
    endtask

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < NL; i++) begin m_st[i] = 2'b00; m_dt[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && coh_req_valid == 1'b0 && done == 1'b0, "R1",
            "reset outputs", int'({req_ready, coh_req_valid, done}), 4);
        // every line Invalid after reset: failed read fills report Invalid, clean
        for (int i = 0; i < NL; i++) run_req(i, 1'b0, 1'b0, 0, 1'b0);
        for (int i = 0; i < NL; i++)
            chk(m_st[i] == 2'b00, "R1", "model invalid", int'(m_st[i]), 0);
        // directed ladder on line 2: I -read-> S -write fail-> S -write-> M -read-> M
        run_req(2, 1'b0, 1'b1, 0, 1'b0);
        run_req(2, 1'b0, 1'b1, 0, 1'b0);
        run_req(2, 1'b1, 1'b0, 2, 1'b1);
        run_req(2, 1'b1, 1'b1, 1, 1'b0);
        run_req(2, 1'b1, 1'b1, 0, 1'b0);
        run_req(2, 1'b0, 1'b1, 0, 1'b0);
        run_req(5, 1'b1, 1'b0, 0, 1'b0);
        run_req(5, 1'b1, 1'b1, 3, 1'b1);
        // pseudo-random sweep
        for (int n = 0; n < 600; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_req(int'(lf[2:0]), lf[3], lf[5:4] != 2'b00, int'(lf[7:6]), lf[8]);
        end
        // final readback of every line: reads report the tracked state
        for (int i = 0; i < NL; i++) run_req(i, 1'b0, 1'b1, 0, 1'b0);
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule